// File: doc/BRIEF.md
# Hot-Plug Command Execution Engine

This block carries out commands for a hot-plug slot controller. A 16-bit command word names a target slot in its upper byte and an operation code in its lower byte. The engine accepts one word at a time, holds it for a fixed number of execution cycles while its busy flag is up, and then either applies the command to the per-slot state and indicator fields or rejects it with an error code. Every finished command, applied or rejected, sets a sticky completion event. That event raises an interrupt output unless the interrupt is masked.

The commands fall into four groups. The first is per-slot operations that pack three independent 2-bit subfields into one code: slot state, power indicator and attention indicator. The second is two all-slot commands, power-only and enable. The third is two speed/mode ranges that load a current bus speed/mode field. The last is reserved and vendor codes, which are flagged as invalid. The command input is a valid/ready stream. A word is taken in a cycle where `cmd_valid_i` and `cmd_ready_o` are both high. Ready is low for the whole execution window. A word offered while ready is low is not taken and not queued, and the source need not hold it.

Top module: `hp_cmd_engine`

## Requirements
- R1: After reset the busy flag and error code are 0, every slot state reads 3 (disabled), every power and attention indicator reads 3 (off), the bus mode reads 0 and the completion event is clear.
- R2: `cmd_ready_o` is the inverse of busy. An accepted word raises busy in the next cycle for exactly EXEC_CYCLES cycles. A word offered while busy has no effect on any field, error code or event. The slot and mode fields change only at the edge where busy falls.
- R3: Bits 15:8 of the command word are the target slot and bits 7:0 are the code. Codes 00h to 3Fh are slot operations. Bits 1:0 set the slot state (1 power-only, 2 enabled, 3 disabled), bits 3:2 set the power indicator and bits 5:4 set the attention indicator (1 on, 2 blink, 3 off). A subfield value of 0 leaves that field as it was. Slot i's fields appear at output bits 2i+1:2i in the same encoding.
- R4: All non-zero subfields of one slot operation take effect together at completion. For example, 3Ah on slot 2 gives state 2, power indicator 2 and attention indicator 3.
- R5: A slot operation whose state subfield is 1 or 2, aimed at a slot whose latch input is high (open), finishes with error 1 and changes none of that slot's fields. A disable (state 3) or an indicator-only operation is allowed with the latch open.
- R6: Code 48h sets every slot to state 1 and code 49h sets every slot to state 2. Both leave the indicators alone and ignore the target byte. If any latch is open, the command finishes with error 1 and nothing changes.
- R7: Codes 40h to 44h load bus mode values 0 to 4. Codes 45h to 47h finish with error 4 and leave the mode unchanged.
- R8: Codes 50h to 5Fh load bus mode value code[3:0]. Values 14 and 15 finish with error 4. With PI_LEVEL 1, any value above 4 also finishes with error 4, and the mode stays unchanged.
- R9: Codes 4Ah to 4Fh, 60h to FFh, and slot operations whose target is at or above NUM_SLOTS, finish with error 2 and change nothing.
- R10: `status_o` bit 0 is busy and bits 3:1 are the error code (0 success, 1 latch open, 2 invalid command, 4 invalid speed/mode). The error code reads 0 while busy, takes the result at completion, has at most one bit set and holds until the next accepted word.
- R11: The completion event sets at the edge where busy falls and stays set until `cmd_evt_clr_i` is high at an edge with no completion; a completion wins over a clear in the same cycle. `cmd_irq_o` is the event ANDed with the inverse of `cmd_irq_mask_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command word offered |
| cmd_ready_o | output | 1 | Engine idle, word will be taken |
| cmd_word_i | input | 16 | Target slot (15:8) and code (7:0) |
| latch_open_i | input | NUM_SLOTS | Per-slot latch sensor, 1 = open |
| cmd_irq_mask_i | input | 1 | 1 masks the completion interrupt |
| cmd_evt_clr_i | input | 1 | Clears the completion event |
| status_o | output | 4 | Error code (3:1) and busy (0) |
| cmd_evt_o | output | 1 | Sticky completion event |
| cmd_irq_o | output | 1 | Completion interrupt |
| slot_state_o | output | 2*NUM_SLOTS | Per-slot state fields |
| pwr_ind_o | output | 2*NUM_SLOTS | Per-slot power indicator fields |
| attn_ind_o | output | 2*NUM_SLOTS | Per-slot attention indicator fields |
| bus_mode_o | output | 4 | Current bus speed/mode value |

## Verification
The bench sweeps every one of the 256 codes across in-range and out-of-range targets, under two latch patterns. It runs two engines side by side, one per interface level, so that it catches the mode ranges being misclassified. A design that applied a range check at the wrong level would either load a mode above 4 at level 1 or reject a legal level-2 mode. A design that checked the latch on disable, or on the wrong slot, would either refuse removals or power a slot behind an open latch. A design that let a word through during busy, or applied results one cycle early, would change fields that the bench expects to be untouched. A design that let the clear beat a same-cycle completion would lose the event.

// File: rtl/hp_cmd_pkg.sv
package hp_cmd_pkg;

  localparam logic [2:0] ERR_NONE  = 3'b000;
  localparam logic [2:0] ERR_LATCH = 3'b001;
  localparam logic [2:0] ERR_CMD   = 3'b010;
  localparam logic [2:0] ERR_MODE  = 3'b100;

  typedef enum logic [2:0] {
    K_SLOT,
    K_MODE_A,
    K_PWR_ALL,
    K_EN_ALL,
    K_MODE_B,
    K_BAD
  } cmd_kind_e;

  // one slot update; a zero subfield means "leave as is"
  typedef struct packed {
    logic [1:0] st;
    logic [1:0] pwr;
    logic [1:0] attn;
  } slot_upd_t;

  function automatic cmd_kind_e classify(input logic [7:0] c);
    if (c < 8'h40)          return K_SLOT;
    else if (c < 8'h48)     return K_MODE_A;
    else if (c == 8'h48)    return K_PWR_ALL;
    else if (c == 8'h49)    return K_EN_ALL;
    else if (c[7:4] == 4'h5) return K_MODE_B;
    else                    return K_BAD;
  endfunction

endpackage

// File: rtl/hp_cmd_decode.sv
module hp_cmd_decode
  import hp_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PI_LEVEL  = 2
) (
  input  logic [7:0]           code_i,
  input  logic [7:0]           tgt_i,
  input  logic [NUM_SLOTS-1:0] latch_i,
  output logic [2:0]           err_o,
  output logic [NUM_SLOTS-1:0] slot_we_o,
  output slot_upd_t            upd_o,
  output logic                 mode_we_o,
  output logic [3:0]           mode_val_o
);

  localparam logic [7:0] SLOT_LIM = 8'(NUM_SLOTS);

  cmd_kind_e            kind;
  logic [NUM_SLOTS-1:0] tgt_sel;
  logic                 tgt_ok;
  logic                 latch_hit;
  logic                 st_up;
  logic [3:0]           mode_a;
  logic [3:0]           mode_b;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
    assign tgt_sel[i] = (tgt_i == 8'(i));
  end

  assign kind      = classify(code_i);
  assign tgt_ok    = (tgt_i < SLOT_LIM);
  assign latch_hit = |(tgt_sel & latch_i);
  assign st_up     = (code_i[1:0] == 2'd1) || (code_i[1:0] == 2'd2);
  assign mode_a    = {1'b0, code_i[2:0]};
  assign mode_b    = code_i[3:0];

  always_comb begin
    err_o      = ERR_NONE;
    slot_we_o  = '0;
    upd_o      = '0;
    mode_we_o  = 1'b0;
    mode_val_o = '0;
    unique case (kind)
      K_SLOT: begin
        if (!tgt_ok) begin
          err_o = ERR_CMD;
        end else if (st_up && latch_hit) begin
          err_o = ERR_LATCH;
        end else begin
          slot_we_o = tgt_sel;
          upd_o     = '{st: code_i[1:0], pwr: code_i[3:2], attn: code_i[5:4]};
        end
      end
      K_PWR_ALL, K_EN_ALL: begin
        if (|latch_i) begin
          err_o = ERR_LATCH;
        end else begin
          slot_we_o = '1;
          upd_o.st  = (kind == K_PWR_ALL) ? 2'd1 : 2'd2;
        end
      end
      K_MODE_A: begin
        if (mode_a > 4'd4) begin
          err_o = ERR_MODE;
        end else begin
          mode_we_o  = 1'b1;
          mode_val_o = mode_a;
        end
      end
      K_MODE_B: begin
        if ((mode_b >= 4'd14) || ((PI_LEVEL == 1) && (mode_b > 4'd4))) begin
          err_o = ERR_MODE;
        end else begin
          mode_we_o  = 1'b1;
          mode_val_o = mode_b;
        end
      end
      default: err_o = ERR_CMD;
    endcase
  end

endmodule

// File: rtl/hp_cmd_seq.sv
module hp_cmd_seq #(
  parameter int EXEC_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [15:0] cmd_word_i,
  input  logic [2:0]  err_next_i,
  input  logic        evt_clr_i,
  output logic        busy_o,
  output logic [15:0] cmd_q_o,
  output logic        done_o,
  output logic [2:0]  err_o,
  output logic        evt_o
);

  localparam int CNT_W = (EXEC_CYCLES > 1) ? $clog2(EXEC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EXEC_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      cmd_q;
  logic [2:0]       err_q;
  logic             evt_q;
  logic             accept;

  assign accept = cmd_valid_i && !busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      err_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LAST;
      cmd_q  <= cmd_word_i;
      err_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
      err_q  <= err_next_i;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        evt_q <= 1'b0;
    else if (done_o)    evt_q <= 1'b1;
    else if (evt_clr_i) evt_q <= 1'b0;
  end

  assign busy_o  = busy_q;
  assign cmd_q_o = cmd_q;
  assign err_o   = err_q;
  assign evt_o   = evt_q;

  a_r2_busy_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(cmd_valid_i));
  a_r2_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> $stable(cmd_q));
  a_r10_err_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(err_q));
  a_r10_err_zero_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (err_q == 3'b000));
  a_r11_evt_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> evt_q);

endmodule

// File: rtl/hp_field_bank.sv
module hp_field_bank
  import hp_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PI_LEVEL  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   apply_i,
  input  logic [NUM_SLOTS-1:0]   slot_we_i,
  input  slot_upd_t              upd_i,
  input  logic                   mode_we_i,
  input  logic [3:0]             mode_val_i,
  input  logic [NUM_SLOTS-1:0]   latch_i,
  output logic [2*NUM_SLOTS-1:0] state_o,
  output logic [2*NUM_SLOTS-1:0] pwr_o,
  output logic [2*NUM_SLOTS-1:0] attn_o,
  output logic [3:0]             mode_o
);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [1:0] st_q, pwr_q, attn_q;
    logic       hit;

    assign hit = apply_i && slot_we_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q   <= 2'd3;
        pwr_q  <= 2'd3;
        attn_q <= 2'd3;
      end else if (hit) begin
        if (upd_i.st   != 2'd0) st_q   <= upd_i.st;
        if (upd_i.pwr  != 2'd0) pwr_q  <= upd_i.pwr;
        if (upd_i.attn != 2'd0) attn_q <= upd_i.attn;
      end
    end

    assign state_o[2*i +: 2] = st_q;
    assign pwr_o[2*i +: 2]   = pwr_q;
    assign attn_o[2*i +: 2]  = attn_q;

    a_r5_latch_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((st_q == 2'd1 || st_q == 2'd2) && !$stable(st_q)) |-> !$past(latch_i[i]));
  end

  logic [3:0] mode_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mode_q <= 4'd0;
    else if (apply_i && mode_we_i)    mode_q <= mode_val_i;
  end
  assign mode_o = mode_q;

  if (PI_LEVEL == 1) begin : g_pi1
    a_r8_pi1_mode_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_q <= 4'd4);
  end

endmodule

// File: rtl/hp_cmd_engine.sv
module hp_cmd_engine
  import hp_cmd_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int EXEC_CYCLES = 4,
  parameter int PI_LEVEL    = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_valid_i,
  output logic                   cmd_ready_o,
  input  logic [15:0]            cmd_word_i,
  input  logic [NUM_SLOTS-1:0]   latch_open_i,
  input  logic                   cmd_irq_mask_i,
  input  logic                   cmd_evt_clr_i,
  output logic [3:0]             status_o,
  output logic                   cmd_evt_o,
  output logic                   cmd_irq_o,
  output logic [2*NUM_SLOTS-1:0] slot_state_o,
  output logic [2*NUM_SLOTS-1:0] pwr_ind_o,
  output logic [2*NUM_SLOTS-1:0] attn_ind_o,
  output logic [3:0]             bus_mode_o
);

  logic                 busy;
  logic                 done;
  logic [15:0]          cmd_q;
  logic [2:0]           err_next;
  logic [2:0]           err_q;
  logic                 evt;
  logic [NUM_SLOTS-1:0] slot_we;
  slot_upd_t            upd;
  logic                 mode_we;
  logic [3:0]           mode_val;

  hp_cmd_seq #(.EXEC_CYCLES(EXEC_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_word_i  (cmd_word_i),
    .err_next_i  (err_next),
    .evt_clr_i   (cmd_evt_clr_i),
    .busy_o      (busy),
    .cmd_q_o     (cmd_q),
    .done_o      (done),
    .err_o       (err_q),
    .evt_o       (evt)
  );

  hp_cmd_decode #(.NUM_SLOTS(NUM_SLOTS), .PI_LEVEL(PI_LEVEL)) u_dec (
    .code_i     (cmd_q[7:0]),
    .tgt_i      (cmd_q[15:8]),
    .latch_i    (latch_open_i),
    .err_o      (err_next),
    .slot_we_o  (slot_we),
    .upd_o      (upd),
    .mode_we_o  (mode_we),
    .mode_val_o (mode_val)
  );

  hp_field_bank #(.NUM_SLOTS(NUM_SLOTS), .PI_LEVEL(PI_LEVEL)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .apply_i    (done),
    .slot_we_i  (slot_we),
    .upd_i      (upd),
    .mode_we_i  (mode_we),
    .mode_val_i (mode_val),
    .latch_i    (latch_open_i),
    .state_o    (slot_state_o),
    .pwr_o      (pwr_ind_o),
    .attn_o     (attn_ind_o),
    .mode_o     (bus_mode_o)
  );

  assign cmd_ready_o = !busy;
  assign status_o    = {err_q, busy};
  assign cmd_evt_o   = evt;
  assign cmd_irq_o   = evt && !cmd_irq_mask_i;

  a_r2_fields_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> ($stable(slot_state_o) && $stable(pwr_ind_o) &&
               $stable(attn_ind_o) && $stable(bus_mode_o)));

endmodule

// File: tb/hp_cmd_engine_tb_top.sv
module hp_cmd_engine_tb_top;

  localparam int N    = 4;
  localparam int EXEC = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n, cmd_valid, mask, clr;
  logic [15:0]    cmd_word;
  logic [N-1:0]   latch;
  logic           ready, evt, irq, ready1, evt1, irq1;
  logic [3:0]     status, status1, mode, mode1;
  logic [2*N-1:0] st, pw, at, st1, pw1, at1;

  hp_cmd_engine #(.NUM_SLOTS(N), .EXEC_CYCLES(EXEC), .PI_LEVEL(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(ready),
    .cmd_word_i(cmd_word), .latch_open_i(latch), .cmd_irq_mask_i(mask),
    .cmd_evt_clr_i(clr), .status_o(status), .cmd_evt_o(evt), .cmd_irq_o(irq),
    .slot_state_o(st), .pwr_ind_o(pw), .attn_ind_o(at), .bus_mode_o(mode));

  hp_cmd_engine #(.NUM_SLOTS(N), .EXEC_CYCLES(EXEC), .PI_LEVEL(1)) dut_pi1_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(ready1),
    .cmd_word_i(cmd_word), .latch_open_i(latch), .cmd_irq_mask_i(mask),
    .cmd_evt_clr_i(clr), .status_o(status1), .cmd_evt_o(evt1), .cmd_irq_o(irq1),
    .slot_state_o(st1), .pwr_ind_o(pw1), .attn_ind_o(at1), .bus_mode_o(mode1));

  int nvec = 0, nfail = 0;
  int m_st[N], m_pw[N], m_at[N];
  int m_mode, m_mode1;

  task automatic check(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pack(input int a[N]);
    int r = 0;
    for (int i = 0; i < N; i++) r = r | ((a[i] & 3) << (2 * i));
    return r;
  endfunction

  function automatic int exp_err(input int pi, input int code, input int tgt,
                                 input logic [N-1:0] lt);
    int v;
    if (code < 'h40) begin
      if (tgt >= N) return 2;
      if (((code & 3) == 1 || (code & 3) == 2) && lt[tgt]) return 1;
      return 0;
    end
    if (code < 'h48) return ((code - 'h40) > 4) ? 4 : 0;
    if (code == 'h48 || code == 'h49) return (lt != '0) ? 1 : 0;
    if (code >= 'h50 && code <= 'h5F) begin
      v = code & 15;
      if (v >= 14) return 4;
      if (pi == 1 && v > 4) return 4;
      return 0;
    end
    return 2;
  endfunction

  function automatic string tag_of(input int code);
    if (code < 'h40) return "R5 slot op error";
    if (code < 'h48) return "R7 set A error";
    if (code < 'h4A) return "R6 all-slot error";
    if (code >= 'h50 && code <= 'h5F) return "R8 set B error";
    return "R9 invalid error";
  endfunction

  task automatic run_cmd(input int tgt, input int code, input bit poke, input bit hold_clr);
    int b, e2, e1, v;
    @(negedge clk);
    check("R2 ready when idle", int'(ready), 1);
    cmd_valid = 1'b1;
    cmd_word  = {8'(tgt), 8'(code)};
    if (hold_clr) clr = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    b = 0;
    while (status[0] && b < EXEC + 3) begin
      b++;
      if (poke && b == 1) begin
        check("R2 ready low while busy", int'(ready), 0);
        check("R10 error zero while busy", int'(status[3:1]), 0);
        cmd_valid = 1'b1;
        cmd_word  = 16'h0031;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    check("R2 busy length", b, EXEC);
    e2 = exp_err(2, code, tgt, latch);
    e1 = exp_err(1, code, tgt, latch);
    if (code < 'h40 && e2 == 0) begin
      if ((code & 3) != 0)        m_st[tgt] = code & 3;
      if (((code >> 2) & 3) != 0) m_pw[tgt] = (code >> 2) & 3;
      if (((code >> 4) & 3) != 0) m_at[tgt] = (code >> 4) & 3;
    end
    if ((code == 'h48 || code == 'h49) && e2 == 0)
      for (int i = 0; i < N; i++) m_st[i] = (code == 'h48) ? 1 : 2;
    if (code >= 'h40 && code < 'h48) v = code - 'h40;
    else v = code & 15;
    if ((code >= 'h40 && code < 'h48) || (code >= 'h50 && code <= 'h5F)) begin
      if (e2 == 0) m_mode  = v;
      if (e1 == 0) m_mode1 = v;
    end
    check(tag_of(code), int'(status[3:1]), e2);
    check({tag_of(code), " (level 1)"}, int'(status1[3:1]), e1);
    check("R3 R4 slot state", int'(st), pack(m_st));
    check("R3 R4 power indicator", int'(pw), pack(m_pw));
    check("R3 R4 attention indicator", int'(at), pack(m_at));
    check("R7 R8 bus mode", int'(mode), m_mode);
    check("R8 bus mode level 1", int'(mode1), m_mode1);
    check("R11 event set", int'(evt), 1);
    check("R11 irq vs mask", int'(irq), int'(!mask));
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R2 no late accept", int'(status[0]), 0);
    check("R11 event cleared", int'(evt), 0);
  endtask

  initial begin
    #1ms;
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; latch = '0; mask = 1'b0; clr = 1'b0;
    for (int i = 0; i < N; i++) begin m_st[i] = 3; m_pw[i] = 3; m_at[i] = 3; end
    m_mode = 0; m_mode1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", int'(status), 0);
    check("R1 ready", int'(ready), 1);
    check("R1 event", int'(evt), 0);
    check("R1 slot state", int'(st), pack(m_st));
    check("R1 power indicator", int'(pw), pack(m_pw));
    check("R1 attention indicator", int'(at), pack(m_at));
    check("R1 bus mode", int'(mode), 0);

    run_cmd(2, 'h3A, 1'b0, 1'b0);           // R4 combined subfields
    latch = 4'b0010;
    run_cmd(1, 'h02, 1'b0, 1'b0);           // R5 enable on open latch
    run_cmd(1, 'h03, 1'b0, 1'b0);           // R5 disable allowed
    run_cmd(1, 'h20, 1'b0, 1'b0);           // R5 indicator-only allowed
    run_cmd(0, 'h48, 1'b0, 1'b0);           // R6 refused, one latch open
    latch = 4'b0000;
    run_cmd(3, 'h49, 1'b0, 1'b0);           // R6 enable all
    run_cmd(0, 'h48, 1'b0, 1'b0);           // R6 power-only all
    run_cmd(2, 'h0C, 1'b1, 1'b0);           // R2 word offered while busy
    run_cmd(0, 'h55, 1'b0, 1'b1);           // R11 set wins over clear; R8 level split
    run_cmd(0, 'h5E, 1'b0, 1'b0);           // R8 reserved value
    run_cmd(7, 'h01, 1'b0, 1'b0);           // R9 target out of range

    for (int pass = 0; pass < 2; pass++) begin
      latch = (pass == 0) ? 4'b0000 : 4'b0101;
      mask  = (pass == 1);
      for (int code = 0; code < 256; code++)
        run_cmd((code * 3 + pass) % 6, code, 1'b0, 1'b0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule